// File: doc/BRIEF.md
# Byte-Wide Configuration Slave Port with Serial Forwarding

This block is the slave side of a byte-wide loading port used while a device is being configured. A host processor selects it with two select lines of opposite polarity. It writes one byte at a time with an active-low write strobe. Before each write it polls readiness through an active-low read strobe, which turns the top data bit into a status output. Each accepted byte is buffered and then sent out on a single serial line, most significant bit first, so that the next device in a daisy chain receives the same data stream.

The strobes are asynchronous to the configuration clock. The select lines and the write strobe pass through a synchroniser of `SYNC_STAGES` flops, and a write is recognised on the high-to-low transition of the synchronised write strobe. The host must hold the data bus stable from the falling write strobe until the accepting clock edge, which is `SYNC_STAGES + 1` rising edges later. The serial output only ever changes on a falling clock edge. The status bit comes straight off the asynchronous strobes, so the host gets an answer within the same bus cycle.

Top module: `cfg_periph_port`

## Requirements
- R1: The port is addressed only when `sel_n_i` is 0 and `sel_i` is 1. A write strobe given while the port is not addressed is not accepted, and the status bit is not driven.
- R2: A write is accepted on the third rising clock edge after `wstb_ni` falls (2 synchroniser flops, then an edge register), when the port is addressed and ready. Exactly one byte is accepted per falling transition, however long the strobe stays low.
- R3: While the port is addressed with `rstb_ni` 0 and `wstb_ni` 1, `stat_oe_o` is 1 and `stat_o` reports 1 for ready and 0 for busy. In every other case `stat_oe_o` is 0.
- R4: When `wstb_ni` and `rstb_ni` are both 0 while the port is addressed, the write is accepted and `stat_oe_o` stays 0.
- R5: The port reports busy from the rising edge that accepts a byte until the falling edge that puts the last bit of that byte on `ser_o`. From then on it reports ready.
- R6: An accepted byte appears on `ser_o` MSB first, one bit per clock period. The first bit appears on the falling edge right after the accepting rising edge. `ser_o` changes only on falling edges, and it holds the last bit while idle.
- R7: A write strobe that falls while the port is busy is ignored. The byte being shifted is not altered, and no extra byte follows it.
- R8: While reset is active, `ser_o` is 0 and the port reports ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock; serial data changes on its falling edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_n_i | input | 1 | Active-low select line |
| sel_i | input | 1 | Active-high select line |
| wstb_ni | input | 1 | Active-low write strobe |
| rstb_ni | input | 1 | Active-low read strobe (status request) |
| din_i | input | DATA_W | Parallel data bus input |
| stat_o | output | 1 | Status on the top data bit: 1 ready, 0 busy |
| stat_oe_o | output | 1 | Output enable for the top data bit |
| ser_o | output | 1 | Serial data to the next device in the chain |

## Verification
A byte whose write strobe falls just after rising edge P0 is accepted at edge P3. Its eight bits are due on `ser_o` at the falling edges that follow P3 through P10. The scoreboard monitor counts those edges from the strobe and samples 2 ns after each falling edge. Busy is probed just after the falling edges that follow P9 and P10, to pin down the exact end of the busy window. The status path is combinational, so it is sampled 1 ns after the read strobe moves. The cases where a write should be ignored are checked by choosing bytes whose last bit differs from the first bit of the rejected byte, then watching `ser_o` for a full byte time afterwards.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  // synchronised strobe bundle, sampled on the rising edge
  typedef struct packed {
    logic sel_n;
    logic sel;
    logic wstb_n;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{sel_n: 1'b1, sel: 1'b0, wstb_n: 1'b1};
  localparam int unsigned STROBE_W = $bits(strobe_t);

endpackage

// File: rtl/cfg_strobe_sync.sv
module cfg_strobe_sync #(
  parameter int unsigned    W       = 3,
  parameter int unsigned    STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [STAGES-1:0][W-1:0] chain_q;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= RST_VAL;
      else         chain_q <= async_i;
    end
  end else begin : g_multi
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
      else         chain_q <= {chain_q[STAGES-2:0], async_i};
    end
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/cfg_write_ctrl.sv
module cfg_write_ctrl #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wstb_n_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] din_i,
  output logic              accept_o,
  output logic [DATA_W-1:0] buf_o,
  output logic              load_tgl_o
);

  logic wstb_prev_q;
  logic wstb_fall;

  assign wstb_fall = wstb_prev_q & ~wstb_n_i;
  // write wins over read: read strobe not consulted here
  assign accept_o  = wstb_fall & sel_i & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wstb_prev_q <= 1'b1;
      buf_o       <= '0;
      load_tgl_o  <= 1'b0;
    end else begin
      wstb_prev_q <= wstb_n_i;
      if (accept_o) begin
        buf_o      <= din_i;
        load_tgl_o <= ~load_tgl_o;
      end
    end
  end

endmodule

// File: rtl/cfg_serial_tx.sv
module cfg_serial_tx #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_tgl_i,
  input  logic [DATA_W-1:0] buf_i,
  output logic              ser_o,
  output logic              busy_o
);

  logic              ack_tgl_q;
  logic [DATA_W-1:0] shift_q;
  logic [CNT_W-1:0]  left_q;
  logic              pend;

  // toggle mismatch = byte handed over, not yet picked up
  assign pend   = load_tgl_i ^ ack_tgl_q;
  assign busy_o = pend | (left_q != '0);

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_tgl_q <= 1'b0;
      shift_q   <= '0;
      left_q    <= '0;
      ser_o     <= 1'b0;
    end else if (pend) begin
      ack_tgl_q <= load_tgl_i;
      ser_o     <= buf_i[DATA_W-1];
      shift_q   <= {buf_i[DATA_W-2:0], 1'b0};
      left_q    <= CNT_W'(DATA_W-1);
    end else if (left_q != '0) begin
      ser_o     <= shift_q[DATA_W-1];
      shift_q   <= {shift_q[DATA_W-2:0], 1'b0};
      left_q    <= left_q - 1'b1;
    end
  end

endmodule

// File: rtl/cfg_periph_port.sv
module cfg_periph_port #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_n_i,
  input  logic              sel_i,
  input  logic              wstb_ni,
  input  logic              rstb_ni,
  input  logic [DATA_W-1:0] din_i,
  output logic              stat_o,
  output logic              stat_oe_o,
  output logic              ser_o
);

  import cfg_port_pkg::*;

  strobe_t           strb_raw, strb_s;
  logic              sel_s;
  logic              accept;
  logic              busy;
  logic              load_tgl;
  logic [DATA_W-1:0] byte_buf;

  assign strb_raw = '{sel_n: sel_n_i, sel: sel_i, wstb_n: wstb_ni};

  cfg_strobe_sync #(
    .W       (STROBE_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (STROBE_IDLE)
  ) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (strb_raw),
    .sync_o  (strb_s)
  );

  assign sel_s = ~strb_s.sel_n & strb_s.sel;

  cfg_write_ctrl #(.DATA_W(DATA_W)) u_wr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel_s),
    .wstb_n_i   (strb_s.wstb_n),
    .busy_i     (busy),
    .din_i      (din_i),
    .accept_o   (accept),
    .buf_o      (byte_buf),
    .load_tgl_o (load_tgl)
  );

  cfg_serial_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_tgl_i (load_tgl),
    .buf_i      (byte_buf),
    .ser_o      (ser_o),
    .busy_o     (busy)
  );

  // status read is combinational off the raw strobes; a write suppresses it
  assign stat_oe_o = ~sel_n_i & sel_i & ~rstb_ni & wstb_ni;
  assign stat_o    = ~busy;

endmodule

// File: rtl/cfg_port_checker.sv
module cfg_port_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic wstb_ni,
  input logic stat_o,
  input logic stat_oe_o,
  input logic ser_o,
  input logic accept_i,
  input logic busy_i
);

  p_accept_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |-> !busy_i);

  p_busy_follows_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> busy_i);

  p_single_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> !accept_i);

  p_no_stat_on_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wstb_ni |-> !stat_oe_o);

  p_stat_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_oe_o && busy_i) |-> !stat_o);

  p_ser_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && $past(!busy_i)) |-> $stable(ser_o));

endmodule

bind cfg_periph_port cfg_port_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wstb_ni   (wstb_ni),
  .stat_o    (stat_o),
  .stat_oe_o (stat_oe_o),
  .ser_o     (ser_o),
  .accept_i  (accept),
  .busy_i    (busy)
);

// File: tb/cfg_periph_port_bench.sv
module cfg_periph_port_bench;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sel_n_i = 1'b0;
  logic       sel_i = 1'b1;
  logic       wstb_ni = 1'b1;
  logic       rstb_ni = 1'b1;
  logic [7:0] din_i = 8'h00;
  logic       stat_o, stat_oe_o, ser_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] exp_q[$];
  event wr_ev;

  always #4 clk_i = ~clk_i;

  cfg_periph_port u_cfg_periph_port (
    .clk_i, .rst_ni, .sel_n_i, .sel_i, .wstb_ni, .rstb_ni, .din_i,
    .stat_o, .stat_oe_o, .ser_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // land 2 ns after the n-th rising edge
  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    #2;
  endtask

  task automatic write_byte(input logic [7:0] b, input bit expect_acc, input int hold);
    din_i   = b;
    wstb_ni = 1'b0;
    if (expect_acc) begin
      exp_q.push_back(b);
      -> wr_ev;
    end
    step(hold);
    wstb_ni = 1'b1;
  endtask

  // idle line must hold a value for one byte time (R1/R7/R2 rejection checks)
  task automatic hold_check(input logic v, input string req);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i); #2;
      chk(ser_o === v, req, ser_o, v);
    end
    step(1);
  endtask

  // scoreboard monitor: bits due on falling edges after accept edge P3
  initial begin
    forever begin
      @(wr_ev);
      repeat (3) @(posedge clk_i);
      if (exp_q.size() != 0) begin
        logic [7:0] e;
        e = exp_q.pop_front();
        for (int i = 7; i >= 0; i--) begin
          @(negedge clk_i); #2;
          chk(ser_o === e[i], "R6 serial bit", ser_o, e[i]);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    chk(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R8 reset state
    rstb_ni = 1'b0;
    #10;
    chk(ser_o === 1'b0, "R8 ser in reset", ser_o, 0);
    chk(stat_oe_o === 1'b1 && stat_o === 1'b1, "R8 ready in reset", {stat_oe_o, stat_o}, 3);
    rstb_ni = 1'b1;
    #1;
    chk(stat_oe_o === 1'b0, "R3 no drive without read", stat_oe_o, 0);
    step(2);
    rst_ni = 1'b1;
    step(2);

    // R2/R5/R6 first byte with exact busy window
    write_byte(8'hA5, 1'b1, 2);
    rstb_ni = 1'b0;
    step(7); #4;
    chk(stat_oe_o === 1'b1 && stat_o === 1'b0, "R5 busy before last bit", {stat_oe_o, stat_o}, 2);
    step(1); #4;
    chk(stat_o === 1'b1, "R5 ready at last bit", stat_o, 1);
    rstb_ni = 1'b1;
    step(2);

    // R6 several patterns
    write_byte(8'h3C, 1'b1, 2); step(12);
    write_byte(8'hFF, 1'b1, 2); step(12);
    write_byte(8'h00, 1'b1, 2); step(12);

    // R7 write while busy ignored (0x5A ends in 0, 0xFF would start with 1)
    write_byte(8'h5A, 1'b1, 2);
    step(1);
    write_byte(8'hFF, 1'b0, 2);
    step(12);
    hold_check(1'b0, "R7 no extra byte");
    rstb_ni = 1'b0; #1;
    chk(stat_o === 1'b1, "R7 ready after ignore", stat_o, 1);
    rstb_ni = 1'b1;
    step(1);

    // R1 deselect: line ends in 1, a rejected 0x00 must not appear
    write_byte(8'h81, 1'b1, 2); step(12);
    sel_n_i = 1'b1; step(3);
    write_byte(8'h00, 1'b0, 2); step(4);
    hold_check(1'b1, "R1 sel_n high ignored");
    rstb_ni = 1'b0; #1;
    chk(stat_oe_o === 1'b0, "R1 no drive sel_n high", stat_oe_o, 0);
    rstb_ni = 1'b1;
    sel_n_i = 1'b0; sel_i = 1'b0; step(3);
    write_byte(8'h00, 1'b0, 2); step(4);
    hold_check(1'b1, "R1 sel low ignored");
    rstb_ni = 1'b0; #1;
    chk(stat_oe_o === 1'b0, "R1 no drive sel low", stat_oe_o, 0);
    rstb_ni = 1'b1;
    sel_i = 1'b1; step(3);

    // R4 write and read together
    rstb_ni = 1'b0;
    din_i = 8'h66; wstb_ni = 1'b0;
    exp_q.push_back(8'h66);
    -> wr_ev;
    #1;
    chk(stat_oe_o === 1'b0, "R4 status suppressed", stat_oe_o, 0);
    step(2);
    wstb_ni = 1'b1;
    rstb_ni = 1'b1;
    step(12);

    // R2 long strobe gives one byte only (0xC3 ends 1, rerun would show 0s)
    write_byte(8'hC3, 1'b1, 20);
    hold_check(1'b1, "R2 single accept");
    hold_check(1'b1, "R2 single accept");

    step(4);
    chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule